// File: doc/BRIEF.md
# Parallel LCD Bus Controller

This block runs an 8-bit parallel bus to an external character or graphic LCD controller. A small CPU-side register port holds the bus timing, the register-select levels, the busy mask and the busy polarity. Each access to the LCD has four phases. In the setup phase the select line is asserted and the register-select and read/write lines are valid. In the width phase the enable strobe is high. The hold phase follows, with the enable strobe low. The gap phase comes last, with the select line released.

A CPU write to the data register starts a bus write. Writing the launch bit of the control register starts a bus read. A CPU read strobe on the data register returns the byte that was last captured and at once starts the next bus read, so software can stream data out of the display. When the busy mask is nonzero, every access is followed by status reads of the LCD. These repeat until every masked bit reads as ready. A busy flag covers the whole sequence. A command that arrives while the flag is set is dropped, and a sticky error bit is set.

Top module: `lcd_pbus_ctrl`

## Requirements
- R1: After reset the bus is idle: select, enable and data drive are low. The status register (address 4) reads 0. The control register (address 1), the busy mask (address 2) and the timing register (address 0) read 0.
- R2: The timing register holds setup in bits [1:0], width in bits [3:2], hold in bits [5:4] and gap in bits [7:6]. Each field gives its phase a length of field+1 clocks. During setup, select is high and enable is low. During width, both are high. During hold, select is high and enable is low.
- R3: Select stays low between two accesses for gap+1 clocks. When control bit 4 is set, that time is width+1 clocks instead.
- R4: A CPU write to the data register (address 3) starts a bus write when control bit 0 (enable) is set. During the access, rw is 0 and rs equals control bit 1. The data drive enable is high only while enable is high in a write, and the bus then carries the written byte.
- R5: A CPU write to the control register with bit 5 set starts a bus read when the interface is enabled. During the access, rw is 1 and the data drive stays off. The bus byte is captured on the last width clock, and the data register returns it.
- R6: A CPU read strobe on the data register returns the captured byte in the same cycle and starts a new bus read. The next byte can then be read back.
- R7: With a nonzero busy mask, each access is followed by status reads. These repeat until no masked bit is busy. Unmasked bits are ignored. A zero mask gives no status reads.
- R8: Control bit 3 set means busy bits are active low. Clear means they are active high.
- R9: During status reads, rs equals control bit 2 and rw is 1.
- R10: Status bit 0 (busy) is high from the cycle after a command until the gap of the final access ends. Its length is the access length times the number of accesses.
- R11: A command during busy is ignored and sets status bit 1 (error). Writing 1 to status bit 1 clears it.
- R12: With control bit 0 clear, data writes and launch writes start nothing and set no error.
- R13: Status reads leave the captured data byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_rd | input | 1 | CPU register read strobe (side effects only) |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data, combinational from address |
| lcd_sel | output | 1 | LCD select, active high |
| lcd_en | output | 1 | LCD enable strobe |
| lcd_rs | output | 1 | LCD register select |
| lcd_rw | output | 1 | LCD read (1) or write (0) |
| lcd_d_out | output | 8 | LCD data bus, outgoing |
| lcd_d_oe | output | 1 | LCD data bus drive enable |
| lcd_d_in | input | 8 | LCD data bus, incoming |

## Verification
The bench measures every phase length at the pins, for the shortest and the longest timing fields. A field decoded off by one would show as a phase that is one clock short or long. A block that ignores bit 4 would keep the plain gap length. The bench runs status polls with one to three busy replies, under both polarities and with unmasked bits set to their busy level. A block that inverts the polarity, ignores the mask or stops polling early shows a wrong pulse count and a wrong busy-flag length. The bench also reads data after status polls, to catch a capture that the status reads overwrite. A second write sent during busy must not reach the bus and must set the error bit. A read strobe must return the old byte and then bring in a new one.

// File: rtl/lcd_pbus_pkg.sv
package lcd_pbus_pkg;
  localparam int unsigned TF_W   = 2;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TIME = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;

  localparam int unsigned C_EN     = 0;
  localparam int unsigned C_RSD    = 1;
  localparam int unsigned C_RSS    = 2;
  localparam int unsigned C_POL    = 3;
  localparam int unsigned C_LCYC   = 4;
  localparam int unsigned C_LAUNCH = 5;
  localparam int unsigned S_BUSY   = 0;
  localparam int unsigned S_ERR    = 1;

  typedef enum logic [2:0] {PH_IDLE, PH_SETUP, PH_WIDTH, PH_HOLD, PH_GAP} phase_e;

  typedef struct packed {
    logic [TF_W-1:0] gap;
    logic [TF_W-1:0] hold;
    logic [TF_W-1:0] width;
    logic [TF_W-1:0] setup;
  } timing_t;

  // Counter load for the gap phase: the width field replaces it when the
  // select-inactive time must match the strobe width.
  function automatic logic [TF_W-1:0] gap_load(timing_t t, logic lcyc);
    return lcyc ? t.width : t.gap;
  endfunction

  // Clocks taken by one complete access, gap included.
  function automatic int unsigned access_cycles(timing_t t, logic lcyc);
    return 32'(t.setup) + 32'(t.width) + 32'(t.hold) + 32'(gap_load(t, lcyc)) + 32'd4;
  endfunction

  // One status bit counts as busy when it is masked in and at its active level.
  function automatic logic bit_busy(logic d, logic m, logic active_low);
    return m & (d ^ active_low);
  endfunction
endpackage

// File: rtl/lcd_pbus_busy.sv
module lcd_pbus_busy
  import lcd_pbus_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] mask,
  input  logic          active_low,
  output logic          busy_any,
  output logic          mask_on
);
  logic [DW-1:0] hit;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign hit[i] = bit_busy(status[i], mask[i], active_low);
  end

  assign busy_any = |hit;
  assign mask_on  = |mask;
endmodule

// File: rtl/lcd_pbus_seq.sv
module lcd_pbus_seq
  import lcd_pbus_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_rd,
  input  timing_t       timing,
  input  logic          lcyc,
  input  logic          rs_data_lvl,
  input  logic          rs_stat_lvl,
  input  logic          mask_on,
  input  logic          status_busy,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] d_in,
  output logic          active,
  output logic          sel,
  output logic          en,
  output logic          rs,
  output logic          rw,
  output logic          d_oe,
  output logic [DW-1:0] d_out,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned CYC_W = 2 + TF_W + 1;

  phase_e          phase_q;
  logic [TF_W-1:0] cnt_q;
  logic            is_rd_q, is_stat_q, ready_q;
  logic [DW-1:0]   wdat_q, rdat_q;

  // named internal events
  logic phase_last, launch, sample_now, gap_end, poll_next, access_done;
  assign phase_last  = (cnt_q == '0);
  assign launch      = start && (phase_q == PH_IDLE);
  assign sample_now  = (phase_q == PH_WIDTH) && phase_last && is_rd_q;
  assign gap_end     = (phase_q == PH_GAP) && phase_last;
  assign poll_next   = gap_end && mask_on && !(is_stat_q && ready_q);
  assign access_done = gap_end && !poll_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      is_rd_q   <= 1'b0;
      is_stat_q <= 1'b0;
      ready_q   <= 1'b0;
      wdat_q    <= '0;
      rdat_q    <= '0;
    end else begin
      if (sample_now) begin
        if (is_stat_q) ready_q <= !status_busy;
        else           rdat_q  <= d_in;
      end
      unique case (phase_q)
        PH_IDLE: if (launch) begin
          phase_q   <= PH_SETUP;
          cnt_q     <= timing.setup;
          is_rd_q   <= start_rd;
          is_stat_q <= 1'b0;
          ready_q   <= 1'b0;
          if (!start_rd) wdat_q <= wdata;
        end
        PH_SETUP: if (phase_last) begin
          phase_q <= PH_WIDTH;
          cnt_q   <= timing.width;
        end else cnt_q <= cnt_q - 1'b1;
        PH_WIDTH: if (phase_last) begin
          phase_q <= PH_HOLD;
          cnt_q   <= timing.hold;
        end else cnt_q <= cnt_q - 1'b1;
        PH_HOLD: if (phase_last) begin
          phase_q <= PH_GAP;
          cnt_q   <= gap_load(timing, lcyc);
        end else cnt_q <= cnt_q - 1'b1;
        PH_GAP: if (poll_next) begin
          phase_q   <= PH_SETUP;
          cnt_q     <= timing.setup;
          is_rd_q   <= 1'b1;
          is_stat_q <= 1'b1;
        end else if (access_done) begin
          phase_q <= PH_IDLE;
        end else cnt_q <= cnt_q - 1'b1;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign active  = (phase_q != PH_IDLE);
  assign sel     = (phase_q == PH_SETUP) || (phase_q == PH_WIDTH) || (phase_q == PH_HOLD);
  assign en      = (phase_q == PH_WIDTH);
  assign rw      = active && is_rd_q;
  assign rs      = is_stat_q ? rs_stat_lvl : rs_data_lvl;
  assign d_oe    = en && !is_rd_q;
  assign d_out   = wdat_q;
  assign rd_data = rdat_q;

  // checker counter: clocks elapsed inside the current access
  logic [CYC_W-1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cyc_q <= '0;
    else if (launch || poll_next)  cyc_q <= '0;
    else if (active)               cyc_q <= cyc_q + 1'b1;
  end

  // R2
  en_after_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(sel));
  // R2
  hold_after_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> sel);
  // R3
  cycle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_end |-> ((32'(cyc_q) + 32'd1) == access_cycles(timing, lcyc)));
  // R7
  poll_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stat_q && !$past(is_stat_q)) |-> $past(mask_on));
  // R4
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(d_out));
endmodule

// File: rtl/lcd_pbus_regs.sv
module lcd_pbus_regs
  import lcd_pbus_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              busy,
  input  logic [DW-1:0]     rd_data,
  output timing_t           timing,
  output logic              enable,
  output logic              rs_data_lvl,
  output logic              rs_stat_lvl,
  output logic              pol_low,
  output logic              lcyc,
  output logic [DW-1:0]     mask,
  output logic              start,
  output logic              start_rd,
  output logic [DW-1:0]     cpu_rdata
);
  localparam int unsigned TIME_W = 4 * TF_W;

  timing_t       timing_q;
  logic          en_q, rsd_q, rss_q, pol_q, lcyc_q, err_q;
  logic [DW-1:0] mask_q;

  logic cmd_write, cmd_launch, cmd_chain, cmd_any, cmd_clash, err_clear;
  assign cmd_write  = cpu_wr && (cpu_addr == A_DATA);
  assign cmd_launch = cpu_wr && (cpu_addr == A_CTRL) && cpu_wdata[C_LAUNCH];
  assign cmd_chain  = cpu_rd && (cpu_addr == A_DATA);
  assign cmd_any    = en_q && (cmd_write || cmd_launch || cmd_chain);
  assign cmd_clash  = cmd_any && busy;
  assign err_clear  = cpu_wr && (cpu_addr == A_STAT) && cpu_wdata[S_ERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= '0;
      en_q     <= 1'b0;
      rsd_q    <= 1'b0;
      rss_q    <= 1'b0;
      pol_q    <= 1'b0;
      lcyc_q   <= 1'b0;
      mask_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      if (cpu_wr && cpu_addr == A_TIME) timing_q <= timing_t'(cpu_wdata[TIME_W-1:0]);
      if (cpu_wr && cpu_addr == A_CTRL) begin
        en_q   <= cpu_wdata[C_EN];
        rsd_q  <= cpu_wdata[C_RSD];
        rss_q  <= cpu_wdata[C_RSS];
        pol_q  <= cpu_wdata[C_POL];
        lcyc_q <= cpu_wdata[C_LCYC];
      end
      if (cpu_wr && cpu_addr == A_MASK) mask_q <= cpu_wdata;
      if (cmd_clash)      err_q <= 1'b1;
      else if (err_clear) err_q <= 1'b0;
    end
  end

  assign timing      = timing_q;
  assign enable      = en_q;
  assign rs_data_lvl = rsd_q;
  assign rs_stat_lvl = rss_q;
  assign pol_low     = pol_q;
  assign lcyc        = lcyc_q;
  assign mask        = mask_q;
  assign start       = cmd_any && !busy;
  assign start_rd    = !cmd_write;

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_TIME: cpu_rdata[TIME_W-1:0] = timing_q;
      A_CTRL: begin
        cpu_rdata[C_EN]   = en_q;
        cpu_rdata[C_RSD]  = rsd_q;
        cpu_rdata[C_RSS]  = rss_q;
        cpu_rdata[C_POL]  = pol_q;
        cpu_rdata[C_LCYC] = lcyc_q;
      end
      A_MASK: cpu_rdata = mask_q;
      A_DATA: cpu_rdata = rd_data;
      A_STAT: begin
        cpu_rdata[S_BUSY] = busy;
        cpu_rdata[S_ERR]  = err_q;
      end
      default: cpu_rdata = '0;
    endcase
  end

  // R11
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(cmd_any && busy));
  // R11
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !err_clear) |=> err_q);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
endmodule

// File: rtl/lcd_pbus_ctrl.sv
module lcd_pbus_ctrl
  import lcd_pbus_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  output logic [DW-1:0]     cpu_rdata,
  output logic              lcd_sel,
  output logic              lcd_en,
  output logic              lcd_rs,
  output logic              lcd_rw,
  output logic [DW-1:0]     lcd_d_out,
  output logic              lcd_d_oe,
  input  logic [DW-1:0]     lcd_d_in
);
  timing_t       timing;
  logic          enable, rs_data_lvl, rs_stat_lvl, pol_low, lcyc;
  logic          start, start_rd, active, busy_any, mask_on;
  logic [DW-1:0] mask, rd_data;

  lcd_pbus_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .busy(active), .rd_data(rd_data),
    .timing(timing), .enable(enable), .rs_data_lvl(rs_data_lvl),
    .rs_stat_lvl(rs_stat_lvl), .pol_low(pol_low), .lcyc(lcyc), .mask(mask),
    .start(start), .start_rd(start_rd), .cpu_rdata(cpu_rdata)
  );

  lcd_pbus_busy #(.DW(DW)) u_busy (
    .status(lcd_d_in), .mask(mask), .active_low(pol_low),
    .busy_any(busy_any), .mask_on(mask_on)
  );

  lcd_pbus_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .timing(timing), .lcyc(lcyc), .rs_data_lvl(rs_data_lvl),
    .rs_stat_lvl(rs_stat_lvl), .mask_on(mask_on), .status_busy(busy_any),
    .wdata(cpu_wdata), .d_in(lcd_d_in), .active(active), .sel(lcd_sel),
    .en(lcd_en), .rs(lcd_rs), .rw(lcd_rw), .d_oe(lcd_d_oe),
    .d_out(lcd_d_out), .rd_data(rd_data)
  );

  // R12
  start_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(enable));
endmodule

// File: tb/lcd_pbus_ctrl_bench.sv
module lcd_pbus_ctrl_bench;
  import lcd_pbus_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;

  typedef struct packed {
    logic [1:0] s, w, h, g;
    logic       lcyc, rd, pol, rsd, rss;
    logic [7:0] mask;
    logic [2:0] nbusy;
    logic [7:0] data;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 8'hA5},
    '{2'd3, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 3'd0, 8'h5A},
    '{2'd1, 2'd2, 2'd0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 8'h3C},
    '{2'd2, 2'd2, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 3'd0, 8'h81},
    '{2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h80, 3'd2, 8'h7E},
    '{2'd1, 2'd0, 2'd1, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'h81, 3'd1, 8'h42},
    '{2'd0, 2'd0, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h0C, 3'd3, 8'h99},
    '{2'd2, 2'd1, 2'd3, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 3'd0, 8'h18}
  };

  logic       clk, rst_n, cpu_wr, cpu_rd;
  logic [2:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata, lcd_d_out, lcd_d_in;
  logic       lcd_sel, lcd_en, lcd_rs, lcd_rw, lcd_d_oe;

  lcd_pbus_ctrl u_lcd_pbus_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .lcd_sel(lcd_sel), .lcd_en(lcd_en), .lcd_rs(lcd_rs), .lcd_rw(lcd_rw),
    .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int m_pulses, m_sels, m_setup, m_width, m_hold, m_gap, m_total, m_oe_bad, m_rs_bad;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic cpu_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_addr = A_STAT;
    #1;
  endtask

  // Walks one command's bus activity until the busy flag drops.
  task automatic monitor(input logic is_rd, input logic [7:0] wval, input logic rsd,
                         input logic rss, input logic [7:0] busyval,
                         input logic [7:0] readyval, input int nbusy);
    int stage = 0;
    int iter = 0;
    logic prev_en = 1'b0;
    logic prev_sel = 1'b0;
    m_pulses = 0; m_sels = 0; m_setup = 0; m_width = 0; m_hold = 0;
    m_gap = 0; m_total = 0; m_oe_bad = 0; m_rs_bad = 0;
    cpu_addr = A_STAT;
    #0;
    while (cpu_rdata[S_BUSY] && iter < 1000) begin
      iter++;
      m_total++;
      if (lcd_sel && !prev_sel) m_sels++;
      if (lcd_en && !prev_en) begin
        m_pulses++;
        if (m_pulses >= 2) lcd_d_in = (m_pulses <= nbusy + 1) ? busyval : readyval;
      end
      if (lcd_sel && m_sels == 1 && (lcd_rs != rsd || lcd_rw != is_rd)) m_rs_bad++;
      if (lcd_sel && m_sels >= 2 && (lcd_rs != rss || !lcd_rw)) m_rs_bad++;
      if (lcd_d_oe && !(lcd_en && m_sels == 1 && !is_rd)) m_oe_bad++;
      if (lcd_en && m_sels == 1 && !is_rd && (!lcd_d_oe || lcd_d_out != wval)) m_oe_bad++;
      case (stage)
        0: if (lcd_en) begin stage = 1; m_width++; end else m_setup++;
        1: if (lcd_en) m_width++; else begin stage = 2; m_hold++; end
        2: if (lcd_sel) m_hold++; else begin stage = 3; m_gap++; end
        3: if (!lcd_sel) m_gap++; else stage = 4;
        default: ;
      endcase
      prev_en = lcd_en;
      prev_sel = lcd_sel;
      @(negedge clk);
      #1;
    end
    if (iter >= 1000) check("R10", "busy flag never cleared", 1, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = A_STAT;
    cpu_wdata = 8'h00; lcd_d_in = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R1 reset state
    check("R1", "status after reset", int'(cpu_rdata), 0);
    check("R1", "sel/en/oe after reset", int'({lcd_sel, lcd_en, lcd_d_oe}), 0);
    cpu_addr = A_CTRL; #1; check("R1", "control after reset", int'(cpu_rdata), 0);
    cpu_addr = A_MASK; #1; check("R1", "mask after reset", int'(cpu_rdata), 0);
    cpu_addr = A_TIME; #1; check("R1", "timing after reset", int'(cpu_rdata), 0);

    // R12 disabled interface ignores commands
    begin
      int sel_seen = 0;
      cpu_write(A_DATA, 8'h77);
      cpu_write(A_CTRL, 8'h20);
      repeat (6) begin
        if (lcd_sel || cpu_rdata[S_BUSY]) sel_seen++;
        @(negedge clk); #1;
      end
      check("R12", "bus activity while disabled", sel_seen, 0);
      check("R12", "error bit while disabled", int'(cpu_rdata[S_ERR]), 0);
    end

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      vec_t v;
      logic [7:0] ctrl, busyval, readyval;
      int gapf, exp_l, exp_p;
      string rq;
      v = VECS[i];
      gapf  = v.lcyc ? int'(v.w) : int'(v.g);
      exp_l = int'(v.s) + int'(v.w) + int'(v.h) + gapf + 4;
      exp_p = (v.mask == 8'h00) ? 1 : int'(v.nbusy) + 2;
      busyval  = v.pol ? ~v.mask : v.mask;
      readyval = v.pol ? v.mask : ~v.mask;
      ctrl = {3'b000, v.lcyc, v.pol, v.rss, v.rsd, 1'b1};
      cpu_write(A_TIME, {v.g, v.h, v.w, v.s});
      cpu_write(A_MASK, v.mask);
      cpu_write(A_CTRL, ctrl);
      if (v.rd) begin
        lcd_d_in = v.data;
        cpu_write(A_CTRL, ctrl | 8'h20);
      end else begin
        lcd_d_in = 8'h00;
        cpu_write(A_DATA, v.data);
      end
      monitor(v.rd, v.data, v.rsd, v.rss, busyval, readyval, int'(v.nbusy));
      check("R2", $sformatf("vec %0d setup clocks", i), m_setup, int'(v.s) + 1);
      check("R2", $sformatf("vec %0d width clocks", i), m_width, int'(v.w) + 1);
      check("R2", $sformatf("vec %0d hold clocks", i), m_hold, int'(v.h) + 1);
      check("R3", $sformatf("vec %0d gap clocks", i), m_gap, gapf + 1);
      rq = v.pol ? "R8" : "R7";
      check(rq, $sformatf("vec %0d strobe count", i), m_pulses, exp_p);
      check("R10", $sformatf("vec %0d busy clocks", i), m_total, exp_l * exp_p);
      check(v.rd ? "R5" : "R4", $sformatf("vec %0d data drive faults", i), m_oe_bad, 0);
      check(v.mask != 8'h00 ? "R9" : "R4", $sformatf("vec %0d rs/rw faults", i), m_rs_bad, 0);
      if (v.rd) begin
        cpu_addr = A_DATA; #1;
        check(v.mask != 8'h00 ? "R13" : "R5", $sformatf("vec %0d read data", i),
              int'(cpu_rdata), int'(v.data));
        cpu_addr = A_STAT; #1;
      end
    end

    // R11 command while busy is dropped and flagged
    cpu_write(A_MASK, 8'h00);
    cpu_write(A_TIME, 8'hFF);
    cpu_write(A_CTRL, 8'h03);
    cpu_write(A_DATA, 8'h55);
    cpu_write(A_DATA, 8'hAA);
    monitor(1'b0, 8'h55, 1'b1, 1'b0, 8'h00, 8'h00, 0);
    check("R11", "strobes after clashing write", m_pulses, 1);
    check("R11", "bus carries first byte only", m_oe_bad, 0);
    check("R11", "error bit set", int'(cpu_rdata[S_ERR]), 1);
    cpu_write(A_STAT, 8'h00);
    check("R11", "error kept on write of 0", int'(cpu_rdata[S_ERR]), 1);
    cpu_write(A_STAT, 8'h02);
    check("R11", "error cleared by write of 1", int'(cpu_rdata[S_ERR]), 0);

    // R6 read strobe returns data and chains the next read
    cpu_write(A_TIME, 8'h00);
    lcd_d_in = 8'h3C;
    cpu_write(A_CTRL, 8'h23);
    monitor(1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 0);
    check("R5", "launch read strobes", m_pulses, 1);
    @(negedge clk);
    cpu_addr = A_DATA; cpu_rd = 1'b1;
    #1;
    check("R6", "read strobe returns captured byte", int'(cpu_rdata), 8'h3C);
    lcd_d_in = 8'hC3;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_addr = A_STAT;
    #1;
    check("R6", "busy right after read strobe", int'(cpu_rdata[S_BUSY]), 1);
    monitor(1'b1, 8'h00, 1'b1, 1'b0, 8'h00, 8'h00, 0);
    check("R6", "chained read strobes", m_pulses, 1);
    check("R6", "chained read rs/rw faults", m_rs_bad, 0);
    cpu_addr = A_DATA; #1;
    check("R6", "chained read data", int'(cpu_rdata), 8'hC3);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule